// File: doc/BRIEF.md
# Tail-pointer write-back issuer

This block converts per-queue completion events into single-beat write requests that deposit an updated tail pointer into a slot in host memory. It serves 24 queues, each split into an outbound half and an inbound half. Every half owns a ring base and a write-back slot address; the two halves of a queue share one ring size, counted in 64-byte units of four 16-byte descriptors. The block only writes and has no read channel at all.

An event names a queue, a direction and a new tail index. If the queue is enabled, the index is wrapped against the ring length and latched as pending for that half. A round-robin arbiter then picks one pending half and presents its write-back address and the tail value on the write address and write data channels. A disabled queue instead bumps a saturating per-queue drop counter. Writes can be frozen either by a software force bit or by a sticky flag raised by an external write-error pulse. While frozen, events stay pending and go out once the freeze lifts.

Configuration uses a word-addressed write/read port. Queue q occupies words q*16 to q*16+8, globals start at word 0x200, and drop counters start at word 0x300.

Top module: `tail_wb_issuer`

## Requirements
- R1: After reset, every ring size reads 10, the enable word reads 0, the control word reads 0, and neither awvalid nor wvalid is asserted.
- R2: Words q*16+{0,1,2,3} hold the outbound ring-base low, ring-base high, slot low and slot high; words q*16+{4..7} hold the same four for the inbound half; word q*16+8 holds the 22-bit ring size. A ring-base low write keeps only bits 31:12 and reads back with bits 11:0 zero; high words keep 26 bits.
- R3: An event on an enabled queue produces exactly one write. awaddr is {slot high[25:0], slot low[31:0]} of the named half (ev_inbound 0 = outbound, 1 = inbound), wdata is the tail zero-extended to 32 bits, and wstrb is 4'hF.
- R4: A tail at or above ring size × 4 is written as 0; any smaller tail is written unchanged.
- R5: Word 0x200 bit q enables queue q. An event on a disabled queue issues no write and increments the drop counter at word 0x300+q, which saturates at 255.
- R6: awvalid and wvalid rise together. Each stays high with stable awaddr/wdata until its own ready is seen, and no new request starts until both have completed.
- R7: Pending halves are numbered q*2+direction and served round-robin: the search starts just after the half served last (slot 47 after reset).
- R8: Word 0x201 bit 0 is a force-freeze; bit 1 reads a sticky freeze flag set by a wr_err pulse and cleared by writing bit 2 as 1. While either is set, no new write starts and events on enabled queues stay pending.
- R9: A second event on a half that is still pending replaces its tail, so only the newest tail is written. An event that arrives in the same cycle that its half is issued stays pending and is written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| ev_valid | input | 1 | Completion event strobe |
| ev_queue | input | 5 | Queue index of the event |
| ev_inbound | input | 1 | Event direction, 1 = inbound half |
| ev_tail | input | 24 | New tail index |
| wr_err | input | 1 | Write-error pulse that raises the sticky freeze |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 58 | Write-back slot address |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 32 | Tail value written |
| wstrb | output | 4 | Byte strobes |

## Verification
The one same-cycle collision this block has is between issuing a half and a fresh event that refills that same half. The bench provokes it by sending two events to one idle half in back-to-back cycles, so the second event is sampled on the edge where the first tail is launched. It then requires two writes, the older tail first and the newer tail second. Freeze and issue also meet: events are queued under a force-freeze and under the error-raised flag, and the bench checks that nothing leaves until the freeze is lifted.

// File: rtl/tail_wb_issuer.sv
module tail_wb_issuer #(
  parameter int NQ       = 24,
  parameter int SIZE_W   = 22,
  parameter int DROP_W   = 8,
  parameter int SIZE_RST = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [9:0]              cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  input  logic                    ev_valid,
  input  logic [$clog2(NQ)-1:0]   ev_queue,
  input  logic                    ev_inbound,
  input  logic [SIZE_W+1:0]       ev_tail,
  input  logic                    wr_err,
  output logic                    awvalid,
  input  logic                    awready,
  output logic [57:0]             awaddr,
  output logic                    wvalid,
  input  logic                    wready,
  output logic [31:0]             wdata,
  output logic [3:0]              wstrb
);
  localparam int QW = $clog2(NQ);
  localparam int SW = QW + 1;
  localparam int NS = 2 * NQ;
  localparam int TW = SIZE_W + 2;

  logic [19:0]       base_lo [NS];
  logic [25:0]       base_hi [NS];
  logic [31:0]       wb_lo   [NS];
  logic [25:0]       wb_hi   [NS];
  logic [SIZE_W-1:0] rsize   [NQ];
  logic [DROP_W-1:0] drop    [NQ];
  logic [TW-1:0]     ptail   [NS];
  logic [NS-1:0]     pend;
  logic [NQ-1:0]     en;
  logic              force_q, auto_q, frozen;
  logic [SW-1:0]     last, gnt;
  logic              gnt_ok, issue;
  logic              aw_q, w_q;
  logic [57:0]       addr_q;
  logic [31:0]       data_q;

  logic [QW-1:0] cq;
  logic [3:0]    ck;
  logic [SW-1:0] cs, ev_s;
  logic          q_wr, g_wr, ev_ok, ev_en;
  logic [TW-1:0] limit, ev_wrap;

  assign cq     = cfg_addr[4 +: QW];
  assign ck     = cfg_addr[3:0];
  assign cs     = {cq, ck[2]};
  assign q_wr   = cfg_wr && !cfg_addr[9] && (cq < NQ);
  assign g_wr   = cfg_wr && (cfg_addr[9:8] == 2'b10);

  assign ev_s    = {ev_queue, ev_inbound};
  assign ev_ok   = ev_valid && (ev_queue < NQ);
  assign ev_en   = ev_ok && en[ev_queue];
  assign limit   = {rsize[ev_queue], 2'b00};
  assign ev_wrap = (ev_tail >= limit) ? '0 : ev_tail;

  assign frozen  = force_q | auto_q;
  assign issue   = gnt_ok && !frozen && !aw_q && !w_q;

  assign awvalid = aw_q;
  assign awaddr  = addr_q;
  assign wvalid  = w_q;
  assign wdata   = data_q;
  assign wstrb   = 4'hF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        base_lo[s] <= '0;
        base_hi[s] <= '0;
        wb_lo[s]   <= '0;
        wb_hi[s]   <= '0;
      end
      for (int q = 0; q < NQ; q++) rsize[q] <= SIZE_W'(SIZE_RST);
      en      <= '0;
      force_q <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      if (q_wr) begin
        if (ck == 4'd8) rsize[cq] <= cfg_wdata[SIZE_W-1:0];
        else if (!ck[3]) begin
          case (ck[1:0])
            2'd0: base_lo[cs] <= cfg_wdata[31:12];
            2'd1: base_hi[cs] <= cfg_wdata[25:0];
            2'd2: wb_lo[cs]   <= cfg_wdata;
            default: wb_hi[cs] <= cfg_wdata[25:0];
          endcase
        end
      end
      if (g_wr && !cfg_addr[0]) en <= cfg_wdata[NQ-1:0];
      if (g_wr &&  cfg_addr[0]) force_q <= cfg_wdata[0];
      if (wr_err) auto_q <= 1'b1;
      else if (g_wr && cfg_addr[0] && cfg_wdata[2]) auto_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) drop[q] <= '0;
    end else if (ev_ok && !en[ev_queue] && (drop[ev_queue] != '1)) begin
      drop[ev_queue] <= drop[ev_queue] + 1'b1;
    end
  end

  always_comb begin
    int t;
    gnt_ok = 1'b0;
    gnt    = last;
    for (int i = 1; i <= NS; i++) begin
      t = int'(last) + i;
      if (t >= NS) t = t - NS;
      if (!gnt_ok && pend[t]) begin
        gnt_ok = 1'b1;
        gnt    = SW'(t);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      for (int s = 0; s < NS; s++) ptail[s] <= '0;
      last   <= SW'(NS - 1);
      aw_q   <= 1'b0;
      w_q    <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (aw_q && awready) aw_q <= 1'b0;
      if (w_q && wready)   w_q  <= 1'b0;
      if (issue) begin
        pend[gnt] <= 1'b0;
        last      <= gnt;
        aw_q      <= 1'b1;
        w_q       <= 1'b1;
        addr_q    <= {wb_hi[gnt], wb_lo[gnt]};
        data_q    <= 32'(ptail[gnt]);
      end
      if (ev_en) begin
        pend[ev_s]  <= 1'b1;
        ptail[ev_s] <= ev_wrap;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_addr[9]) begin
      if (cq < NQ) begin
        if (ck == 4'd8) cfg_rdata = 32'(rsize[cq]);
        else if (!ck[3]) begin
          case (ck[1:0])
            2'd0: cfg_rdata = {base_lo[cs], 12'h000};
            2'd1: cfg_rdata = 32'(base_hi[cs]);
            2'd2: cfg_rdata = wb_lo[cs];
            default: cfg_rdata = 32'(wb_hi[cs]);
          endcase
        end
      end
    end else if (!cfg_addr[8]) begin
      cfg_rdata = cfg_addr[0] ? {30'd0, auto_q, force_q} : 32'(en);
    end else if (cfg_addr[QW-1:0] < NQ) begin
      cfg_rdata = 32'(drop[cfg_addr[QW-1:0]]);
    end
  end
endmodule

// File: rtl/tail_wb_issuer_chk.sv
module tail_wb_issuer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        awvalid,
  input logic        awready,
  input logic [57:0] awaddr,
  input logic        wvalid,
  input logic        wready,
  input logic [31:0] wdata,
  input logic        frozen
);
  a_r6_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));

  a_r6_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata));

  a_r6_paired_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awvalid) |-> $rose(wvalid));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> !$rose(awvalid));

  a_r8_frozen_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> !$rose(awvalid));
endmodule

bind tail_wb_issuer tail_wb_issuer_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
  .wvalid(wvalid), .wready(wready), .wdata(wdata),
  .frozen(frozen)
);

// File: tb/tail_wb_issuer_tb.sv
`timescale 1ns/100ps
module tail_wb_issuer_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        ev_valid = 0, ev_inbound = 0, wr_err = 0;
  logic [4:0]  ev_queue = '0;
  logic [23:0] ev_tail = '0;
  logic        awvalid, wvalid, awready = 1, wready = 1;
  logic [57:0] awaddr;
  logic [31:0] wdata;
  logic [3:0]  wstrb;

  always #2.5 clk = ~clk;

  tail_wb_issuer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_valid(ev_valid),
    .ev_queue(ev_queue), .ev_inbound(ev_inbound), .ev_tail(ev_tail),
    .wr_err(wr_err), .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb)
  );

  int checks = 0, fails = 0;
  logic [57:0] cap_addr [64];
  logic [35:0] cap_data [64];
  int na = 0, nd = 0;

  always @(posedge clk) if (rst_n) begin
    if (awvalid && awready && na < 64) begin cap_addr[na] = awaddr; na++; end
    if (wvalid && wready && nd < 64) begin cap_data[nd] = {wstrb, wdata}; nd++; end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic send_event(input int q, input bit dir, input logic [23:0] t);
    ev_valid = 1; ev_queue = 5'(q); ev_inbound = dir; ev_tail = t;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic wait_writes(input int n);
    int guard = 0;
    while ((na < n || nd < n) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic logic [57:0] exp_addr(input int q, input bit d);
    if (!d) return {26'(q + 1), 32'h1000_0000 + 32'(q * 256)};
    return {26'h3FF_0000 | 26'(q), 32'h2000_0040 + 32'(q * 8)};
  endfunction

  // {queue[5], inbound[1], tail[24], expected data[24]}
  localparam logic [53:0] VEC [8] = '{
    {5'd0,  1'b0, 24'd7,        24'd7},
    {5'd0,  1'b1, 24'd39,       24'd39},
    {5'd7,  1'b0, 24'd40,       24'd0},
    {5'd5,  1'b1, 24'd11,       24'd11},
    {5'd5,  1'b0, 24'd12,       24'd0},
    {5'd21, 1'b1, 24'd0,        24'd0},
    {5'd12, 1'b0, 24'hFFFFFF,   24'd0},
    {5'd1,  1'b0, 24'd20,       24'd20}
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    cfg_read(10'd8, rd);      chk(rd == 32'd10, "R1 ring size", rd, 10);
    cfg_read(10'h200, rd);    chk(rd == 0, "R1 enable", rd, 0);
    cfg_read(10'h201, rd);    chk(rd == 0, "R1 control", rd, 0);
    chk(!awvalid && !wvalid, "R1 no request", {awvalid, wvalid}, 0);

    // R2 field masking
    cfg_write(10'd0, 32'hFFFF_FFFF);
    cfg_read(10'd0, rd);      chk(rd == 32'hFFFF_F000, "R2 base low aligned", rd, 32'hFFFF_F000);
    cfg_write(10'd1, 32'hFFFF_FFFF);
    cfg_read(10'd1, rd);      chk(rd == 32'h03FF_FFFF, "R2 base high 26 bits", rd, 32'h03FF_FFFF);

    for (int q = 0; q < 24; q++) begin
      cfg_write(10'(q*16+2), exp_addr(q, 0)[31:0]);
      cfg_write(10'(q*16+3), 32'(exp_addr(q, 0)[57:32]));
      cfg_write(10'(q*16+6), exp_addr(q, 1)[31:0]);
      cfg_write(10'(q*16+7), 32'(exp_addr(q, 1)[57:32]));
    end
    cfg_write(10'(5*16+8), 32'd3);
    cfg_read(10'(5*16+8), rd); chk(rd == 3, "R2 ring size write", rd, 3);
    cfg_write(10'h200, 32'h003F_FFFF);
    cfg_read(10'h200, rd);    chk(rd == 32'h003F_FFFF, "R5 enable readback", rd, 32'h003F_FFFF);

    // R3/R4 vector walk
    for (int i = 0; i < 8; i++) begin
      base = na;
      send_event(int'(VEC[i][53:49]), VEC[i][48], VEC[i][47:24]);
      wait_writes(base + 1);
      chk(cap_addr[base] == exp_addr(int'(VEC[i][53:49]), VEC[i][48]), "R3 write address",
          64'(cap_addr[base]), 64'(exp_addr(int'(VEC[i][53:49]), VEC[i][48])));
      chk(cap_data[base] == {4'hF, 8'h00, VEC[i][23:0]}, "R4 tail data/strobe",
          64'(cap_data[base]), 64'({4'hF, 8'h00, VEC[i][23:0]}));
    end

    // R7/R8/R9 round robin under force freeze, with coalescing
    cfg_write(10'h201, 32'd1);
    base = na;
    send_event(0, 0, 24'd1);
    send_event(2, 0, 24'd5);
    send_event(3, 1, 24'd2);
    send_event(10, 0, 24'd3);
    send_event(2, 0, 24'd9);
    repeat (8) @(negedge clk);
    chk(na == base, "R8 force freeze holds", na, base);
    cfg_read(10'h201, rd);    chk(rd == 1, "R8 force bit", rd, 1);
    cfg_write(10'h201, 32'd0);
    wait_writes(base + 4);
    chk(na == base + 4, "R9 coalesced count", na, base + 4);
    chk(cap_addr[base]   == exp_addr(2, 0),  "R7 order 1st", 64'(cap_addr[base]),   64'(exp_addr(2, 0)));
    chk(cap_data[base][31:0] == 9,           "R9 newest tail", 64'(cap_data[base]), 9);
    chk(cap_addr[base+1] == exp_addr(3, 1),  "R7 order 2nd", 64'(cap_addr[base+1]), 64'(exp_addr(3, 1)));
    chk(cap_addr[base+2] == exp_addr(10, 0), "R7 order 3rd", 64'(cap_addr[base+2]), 64'(exp_addr(10, 0)));
    chk(cap_addr[base+3] == exp_addr(0, 0),  "R7 order 4th", 64'(cap_addr[base+3]), 64'(exp_addr(0, 0)));

    // R8 sticky freeze from wr_err
    @(negedge clk); wr_err = 1; @(negedge clk); wr_err = 0;
    base = na;
    send_event(4, 1, 24'd3);
    repeat (10) @(negedge clk);
    chk(na == base, "R8 error freeze holds", na, base);
    cfg_read(10'h201, rd);    chk(rd == 2, "R8 sticky flag", rd, 2);
    cfg_write(10'h201, 32'd4);
    wait_writes(base + 1);
    chk(na == base + 1 && cap_addr[base] == exp_addr(4, 1) && cap_data[base][31:0] == 3,
        "R8 release after clear", 64'(cap_data[base]), 3);
    cfg_read(10'h201, rd);    chk(rd == 0, "R8 flag cleared", rd, 0);

    // R6 handshake hold
    repeat (3) @(negedge clk);
    awready = 0; wready = 0;
    base = na;
    send_event(0, 0, 24'd3);
    repeat (4) @(negedge clk);
    chk(awvalid && wvalid && awaddr == exp_addr(0, 0) && wdata == 3, "R6 valids held",
        64'(awaddr), 64'(exp_addr(0, 0)));
    wready = 1;
    @(negedge clk);
    chk(!wvalid && awvalid, "R6 independent channels", {wvalid, awvalid}, 2'b01);
    awready = 1;
    @(negedge clk);
    chk(!awvalid && na == base + 1 && nd == base + 1, "R6 completes", na, base + 1);

    // R9 event collides with issue of its own half
    repeat (3) @(negedge clk);
    base = na;
    send_event(3, 0, 24'd1);
    send_event(3, 0, 24'd2);
    wait_writes(base + 2);
    chk(na == base + 2, "R9 collision keeps second", na, base + 2);
    chk(cap_data[base][31:0] == 1 && cap_data[base+1][31:0] == 2, "R9 collision order",
        {32'(cap_data[base][31:0]), 32'(cap_data[base+1][31:0])}, {32'd1, 32'd2});

    // R5 disabled queues drop and saturate
    base = na;
    for (int i = 0; i < 3; i++) send_event(23, i[0], 24'd1);
    for (int i = 0; i < 300; i++) send_event(22, 0, 24'd1);
    repeat (6) @(negedge clk);
    chk(na == base, "R5 no write when disabled", na, base);
    cfg_read(10'h317, rd);    chk(rd == 3, "R5 drop count", rd, 3);
    cfg_read(10'h316, rd);    chk(rd == 255, "R5 drop saturates", rd, 255);
    cfg_read(10'h300, rd);    chk(rd == 0, "R5 enabled queue no drop", rd, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule